// File: doc/BRIEF.md
# Indirect Transfer Byte FIFO

This block is a sixteen-byte buffer that sits between a 32-bit register port and a byte-wide serial engine during indirect transfers. The direction input chooses which side fills the buffer. In write direction, software pushes 1, 2 or 4 bytes per register write, and the serial engine drains one byte at a time. In read direction, the serial engine deposits bytes one at a time, and software removes 1, 2 or 4 bytes per register read. A register access that cannot be served yet is held off: its acknowledge stays low until enough space or data is there. A read is also released once the transfer has ended, and it then returns whatever bytes remain.

A programmable threshold drives a level flag. In write direction it counts free bytes. In read direction it counts valid bytes, and it also stays up while bytes remain after the serial reads have finished. A fill-level output reports the byte count and can be forced to zero for modes that do not use the buffer. A flush input empties the buffer in a single clock, for use when a transfer is aborted. The reset is asynchronous and active low, and its release is synchronised inside the block, so the buffer is usable two clocks after `rst_n` rises.

Top module: `xfer_byte_fifo`

## Requirements
- R1: After reset the level output reads 0 and `ser_empty` is 1.
- R2: In write direction (`dir_rd`=0), a register write with `reg_size` code 0, 1, 2 or 3 adds 1, 2, 4 or 4 bytes. The bytes are taken little-endian from `reg_wdata`, with bits 7:0 first. The serial side then presents them on `ser_rdata` in that order, and `ser_pop` removes one byte at a time.
- R3: In write direction, `reg_ack` stays low for a pending write while the free space is smaller than the access size. The write completes in the first cycle that has enough space.
- R4: In read direction (`dir_rd`=1), `ser_push` appends `ser_wdata`. An acknowledged register read removes the access size in bytes and returns them little-endian, with the oldest byte in bits 7:0. Lanes above the bytes it removes read zero.
- R5: In read direction, a register read waits while fewer bytes than its size are held and `xfer_done` is 0. If `xfer_done` is 1, the read completes at once and removes only the bytes present, which may be none.
- R6: The level counts 0 to 16 bytes. One cycle after a serial-side and a register-side transfer that happen in the same cycle, the level shows their net effect.
- R7: In write direction with threshold T, the flag is 1 exactly when at least T+1 bytes are free.
- R8: In read direction with threshold T, the flag is 1 when at least T+1 bytes are held, or when `xfer_done` is 1 and at least one byte is held. Otherwise it is 0.
- R9: While `level_hide` is 1 the level output reads 0. The contents are kept and reappear when `level_hide` returns to 0.
- R10: A cycle with `flush` set empties the buffer by the next cycle. That cycle acknowledges no register access, and any same-cycle push is lost.
- R11: A serial push when 16 bytes are held, or a serial pop when the buffer is empty, is ignored.
- R12: An access that does not match the direction has no effect: a register write in read direction, a register read in write direction, a serial push in write direction, or a serial pop in read direction. A register access of this kind is acknowledged at once, and a register read of this kind returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rd | input | 1 | 1: read direction (serial fills), 0: write direction (register fills) |
| xfer_done | input | 1 | Serial transfer has finished |
| level_hide | input | 1 | Force level output to zero |
| thresh | input | 4 | Threshold value T |
| flush | input | 1 | Empty the buffer |
| reg_req | input | 1 | Register access pending |
| reg_wr | input | 1 | 1: write, 0: read |
| reg_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| reg_wdata | input | 32 | Register write data |
| reg_ack | output | 1 | Access completes this cycle |
| reg_rdata | output | 32 | Register read data, valid with `reg_ack` |
| ser_push | input | 1 | Serial byte in (read direction) |
| ser_wdata | input | 8 | Serial byte to store |
| ser_pop | input | 1 | Serial byte out (write direction) |
| ser_rdata | output | 8 | Oldest byte held |
| ser_full | output | 1 | 16 bytes held |
| ser_empty | output | 1 | No byte held |
| level | output | 5 | Fill level in bytes |
| thr_flag | output | 1 | Threshold flag |

## Verification
A wrong pointer or byte count shows up in a bounded number of cycles. A bad read pointer puts a wrong byte on `ser_rdata`, or in a read lane, on the very next access. A count error shows on `level` one cycle after the transfer that caused it. It also moves `thr_flag` and the stall decision in that same cycle, because both are derived from the count. Lost or duplicated bytes under same-cycle push and pop cannot hide: they shift every later byte the model expects. The random phase with a reference queue therefore exposes them within a few accesses.

// File: rtl/xbf_pkg.sv
package xbf_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } xbf_size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (xbf_size_e'(code))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/xbf_store.sv
module xbf_store #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [2:0]           push_n,
  input  logic [LANES*8-1:0]   push_data,
  input  logic [2:0]           pop_n,
  output logic [LANES*8-1:0]   peek_data
);

  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic          wp_en, rp_en;
  logic [7:0]    mem [DEPTH];

  always_comb begin
    wp_en = flush || (push_n != 3'd0);
    rp_en = flush || (pop_n != 3'd0);
    wp_d  = flush ? '0 : wp_q + PW'(push_n);
    rp_d  = flush ? '0 : rp_q + PW'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wp_en) wp_q <= wp_d;
      if (rp_en) rp_q <= rp_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic       we;
    logic [7:0] wd;
    always_comb begin
      we = 1'b0;
      wd = '0;
      for (int l = 0; l < LANES; l++) begin
        if (!flush && (l < int'(push_n)) && ((wp_q + PW'(l)) == PW'(e))) begin
          we = 1'b1;
          wd = push_data[l*8 +: 8];
        end
      end
    end
    always_ff @(posedge clk) begin
      if (we) mem[e] <= wd;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_peek
    assign peek_data[l*8 +: 8] = mem[rp_q + PW'(l)];
  end

endmodule

// File: rtl/xbf_level.sv
module xbf_level #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [2:0]    push_n,
  input  logic [2:0]    pop_n,
  input  logic          hide,
  output logic [CW-1:0] count,
  output logic [CW-1:0] level
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = flush || (push_n != 3'd0) || (pop_n != 3'd0);
    cnt_d  = flush ? '0 : cnt_q + CW'(push_n) - CW'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign level = hide ? '0 : cnt_q;

  // R6
  cnt_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));

endmodule

// File: rtl/xbf_thresh.sv
module xbf_thresh #(
  parameter int DEPTH = 16,
  parameter int TW = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          dir_rd,
  input  logic          done,
  input  logic [TW-1:0] thresh,
  output logic          flag
);

  int need, held, space;

  always_comb begin
    need  = int'(thresh) + 1;
    held  = int'(count);
    space = DEPTH - held;
    if (dir_rd) flag = (held >= need) || (done && (held != 0));
    else        flag = (space >= need);
  end

  // R7
  empty_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && (count == '0)) |-> flag);

  // R8
  empty_rd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && (count == '0)) |-> !flag);

endmodule

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int TW = 4,
  parameter int REG_W = 32,
  localparam int LANES = REG_W / 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rd,
  input  logic             xfer_done,
  input  logic             level_hide,
  input  logic [TW-1:0]    thresh,
  input  logic             flush,
  input  logic             reg_req,
  input  logic             reg_wr,
  input  logic [1:0]       reg_size,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             reg_ack,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ser_push,
  input  logic [7:0]       ser_wdata,
  input  logic             ser_pop,
  output logic [7:0]       ser_rdata,
  output logic             ser_full,
  output logic             ser_empty,
  output logic [CW-1:0]    level,
  output logic             thr_flag
);

  import xbf_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [CW-1:0]      cnt;
  logic [CW-1:0]      space;
  logic [2:0]         nb, take, push_n, pop_n;
  logic [LANES*8-1:0] push_data, peek_data;
  logic               rd_ok, wr_ok;

  always_comb begin
    nb       = size_bytes(reg_size);
    space    = CW'(DEPTH) - cnt;
    ser_full = (cnt == CW'(DEPTH));
    ser_empty = (cnt == '0);
    rd_ok    = (cnt >= CW'(nb)) || xfer_done;
    wr_ok    = (space >= CW'(nb));
    take     = (cnt >= CW'(nb)) ? nb : 3'(cnt);
    reg_ack  = 1'b0;
    push_n   = 3'd0;
    pop_n    = 3'd0;
    push_data = '0;
    if (!flush) begin
      if (dir_rd) begin
        if (reg_req) reg_ack = reg_wr ? 1'b1 : rd_ok;
        if (reg_req && !reg_wr && rd_ok) pop_n = take;
        if (ser_push && !ser_full) begin
          push_n = 3'd1;
          push_data[7:0] = ser_wdata;
        end
      end else begin
        if (reg_req) reg_ack = reg_wr ? wr_ok : 1'b1;
        if (reg_req && reg_wr && wr_ok) begin
          push_n    = nb;
          push_data = reg_wdata[LANES*8-1:0];
        end
        if (ser_pop && !ser_empty) pop_n = 3'd1;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rlane
    assign reg_rdata[l*8 +: 8] = (dir_rd && (l < int'(pop_n))) ? peek_data[l*8 +: 8] : 8'h00;
  end
  assign ser_rdata = peek_data[7:0];

  xbf_store #(.DEPTH(DEPTH), .LANES(LANES)) i_store (
    .clk(clk), .rst_n(rst_i), .flush(flush),
    .push_n(push_n), .push_data(push_data),
    .pop_n(pop_n), .peek_data(peek_data)
  );

  xbf_level #(.DEPTH(DEPTH)) i_level (
    .clk(clk), .rst_n(rst_i), .flush(flush),
    .push_n(push_n), .pop_n(pop_n), .hide(level_hide),
    .count(cnt), .level(level)
  );

  xbf_thresh #(.DEPTH(DEPTH), .TW(TW)) i_thresh (
    .clk(clk), .rst_n(rst_i), .count(cnt), .dir_rd(dir_rd),
    .done(xfer_done), .thresh(thresh), .flag(thr_flag)
  );

  // R3
  wr_grows_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_ack && reg_wr && !dir_rd && !ser_pop) |=> (cnt == $past(cnt) + CW'($past(nb))));

  // R4
  rd_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_ack && !reg_wr && dir_rd && !ser_push && !xfer_done) |=> (cnt == $past(cnt) - CW'($past(nb))));

  // R5
  rd_drain_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_ack && !reg_wr && dir_rd && !ser_push && (cnt < CW'(nb))) |=> (cnt == '0));

  // R10
  no_ack_flush_chk: assert property (@(posedge clk) disable iff (!rst_i)
    flush |-> !reg_ack);

endmodule

// File: tb/test_xfer_byte_fifo.sv
module test_xfer_byte_fifo;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dir_rd, xfer_done, level_hide, flush;
  logic [3:0]  thresh;
  logic        reg_req, reg_wr;
  logic [1:0]  reg_size;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_ack;
  logic        ser_push, ser_pop, ser_full, ser_empty, thr_flag;
  logic [7:0]  ser_wdata, ser_rdata;
  logic [4:0]  level;

  always #2.5 clk = ~clk;

  xfer_byte_fifo i_xfer_byte_fifo (
    .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .xfer_done(xfer_done),
    .level_hide(level_hide), .thresh(thresh), .flush(flush),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .ser_push(ser_push), .ser_wdata(ser_wdata), .ser_pop(ser_pop),
    .ser_rdata(ser_rdata), .ser_full(ser_full), .ser_empty(ser_empty),
    .level(level), .thr_flag(thr_flag)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] q[$];
  logic dir_v = 1'b0, done_v = 1'b0, hide_v = 1'b0;
  logic [3:0] thr_v = 4'd0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic cyc(input logic f, input logic rq, input logic w, input logic [1:0] sz,
                     input logic [31:0] wd, input logic sp, input logic [7:0] sd, input logic so);
    int n, held, tk;
    logic eack, eflag;
    logic [31:0] erd;
    @(negedge clk);
    dir_rd = dir_v; xfer_done = done_v; level_hide = hide_v; thresh = thr_v;
    flush = f; reg_req = rq; reg_wr = w; reg_size = sz; reg_wdata = wd;
    ser_push = sp; ser_wdata = sd; ser_pop = so;
    #1;
    n = nbytes(sz);
    held = q.size();
    chk(level == (hide_v ? 5'd0 : 5'(held)), hide_v ? "R9 level hidden" : "R6 level", 32'(level), 32'(hide_v ? 0 : held));
    chk(ser_empty == (held == 0), "R6 empty", 32'(ser_empty), 32'(held == 0));
    if (dir_v) eflag = (held >= int'(thr_v) + 1) || (done_v && held != 0);
    else       eflag = (16 - held >= int'(thr_v) + 1);
    chk(thr_flag == eflag, dir_v ? "R8 flag" : "R7 flag", 32'(thr_flag), 32'(eflag));
    if (!dir_v && held > 0) chk(ser_rdata == q[0], "R2 serial byte", 32'(ser_rdata), 32'(q[0]));
    if (f) eack = 1'b0;
    else if (!rq) eack = 1'b0;
    else if (w) eack = dir_v ? 1'b1 : (16 - held >= n);
    else eack = dir_v ? (held >= n || done_v) : 1'b1;
    chk(reg_ack == eack, f ? "R10 ack" : (dir_v ? "R5 ack" : "R3 ack"), 32'(reg_ack), 32'(eack));
    tk = 0;
    erd = '0;
    if (eack && !w && dir_v) begin
      tk = (held >= n) ? n : held;
      for (int i = 0; i < tk; i++) erd[i*8 +: 8] = q[i];
    end
    if (eack && !w) chk(reg_rdata == erd, dir_v ? "R4 read data" : "R12 read data", reg_rdata, erd);
    if (f) q.delete();
    else begin
      for (int i = 0; i < tk; i++) void'(q.pop_front());
      if (so && !dir_v && held > 0) void'(q.pop_front());
      if (eack && w && !dir_v) for (int i = 0; i < n; i++) q.push_back(wd[i*8 +: 8]);
      if (sp && dir_v && held < 16) q.push_back(sd);
    end
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    dir_rd = 0; xfer_done = 0; level_hide = 0; thresh = 0; flush = 0;
    reg_req = 0; reg_wr = 0; reg_size = 0; reg_wdata = 0;
    ser_push = 0; ser_wdata = 0; ser_pop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    chk(level == 5'd0, "R1 level", 32'(level), 0);
    chk(ser_empty == 1'b1, "R1 empty", 32'(ser_empty), 1);

    // R2: write direction, little-endian word, half, byte, size code 3
    dir_v = 0; thr_v = 4'd3;
    cyc(0, 1, 1, 2'd2, 32'h44332211, 0, 0, 0);
    cyc(0, 1, 1, 2'd1, 32'hAAAA6655, 0, 0, 0);
    cyc(0, 1, 1, 2'd0, 32'hBBBBBB77, 0, 0, 0);
    cyc(0, 1, 1, 2'd3, 32'hDDCCBBA8, 0, 0, 0);
    repeat (4) cyc(0, 0, 0, 0, 0, 0, 0, 1);
    // R3: fill then stall
    repeat (3) cyc(0, 1, 1, 2'd2, 32'h0F0E0D0C, 0, 0, 1);
    cyc(0, 1, 1, 2'd2, 32'h13121110, 0, 0, 0);
    cyc(0, 1, 1, 2'd0, 32'h99, 0, 0, 0);
    cyc(0, 1, 1, 2'd1, 32'h1234, 0, 0, 1);
    cyc(0, 1, 1, 2'd1, 32'h1234, 0, 0, 0);
    // R11: pop ignored when empty after draining
    repeat (20) cyc(0, 0, 0, 0, 0, 0, 0, 1);
    // R12: wrong direction accesses
    cyc(0, 1, 0, 2'd2, 0, 1, 8'h5A, 0);
    idle();
    // R9: hidden level keeps contents
    cyc(0, 1, 1, 2'd2, 32'hCAFEF00D, 0, 0, 0);
    hide_v = 1; idle(); idle();
    hide_v = 0; idle();
    // R10: flush with a same-cycle write
    cyc(1, 1, 1, 2'd2, 32'h01020304, 0, 0, 1);
    idle();

    // R4/R5: read direction
    dir_v = 1; thr_v = 4'd4; done_v = 0;
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 1, 8'(8'h30 + i), 0);
    cyc(0, 1, 0, 2'd2, 0, 0, 0, 0);
    cyc(0, 1, 0, 2'd2, 0, 0, 0, 0);
    cyc(0, 1, 0, 2'd1, 0, 1, 8'h41, 0);
    done_v = 1;
    idle();
    cyc(0, 1, 0, 2'd2, 0, 0, 0, 0);
    cyc(0, 1, 0, 2'd2, 0, 0, 0, 0);
    done_v = 0;
    // R11: push ignored when full; R12 writes and pops ignored
    for (int i = 0; i < 18; i++) cyc(0, 0, 0, 0, 0, 1, 8'(8'h60 + i), 0);
    cyc(0, 1, 1, 2'd0, 32'hEE, 0, 0, 1);
    // R6: simultaneous push and pop
    cyc(0, 1, 0, 2'd0, 0, 1, 8'h77, 0);
    cyc(0, 1, 0, 2'd1, 0, 1, 8'h78, 0);
    idle();
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    idle();

    // random phase, both directions
    void'($urandom(32'd20240611));
    for (int k = 0; k < 6000; k++) begin
      logic f, rq, w, sp, so;
      if (k % 1500 == 0) begin
        dir_v = ~dir_v;
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
      end
      if (k % 40 == 0) thr_v = 4'($urandom);
      done_v = dir_v && ($urandom % 6 == 0);
      hide_v = ($urandom % 25 == 0);
      f  = ($urandom % 97 == 0);
      rq = ($urandom % 2 == 0);
      w  = dir_v ? ($urandom % 10 == 0) : ($urandom % 10 != 0);
      sp = ($urandom % 3 != 0);
      so = ($urandom % 3 != 0);
      cyc(f, rq, w, 2'($urandom), $urandom, sp, 8'($urandom), so);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule